// File: doc/BRIEF.md
# Cascadable Column Segment Loader

This block is the column-side front end of a display segment driver. Pixel data arrives on a parallel bus one word per shift strobe. The bus is 4 bits wide or 8 bits wide, chosen by a mode pin. Each word is written into a line buffer with one bit per output channel. A direction pin sets whether the buffer fills from the low channels upward or from the high channels downward. The same pin decides which of the two enable pins acts as the input and which acts as the output.

In a cascade, the first chip has its enable input tied low. A chip takes data only while its enable input is low and its buffer is not yet full. Once the last word of the line has been taken, the chip pulls its enable output low, which hands the bus to the next chip.

A falling edge on the line pulse copies the whole buffer into an output latch and re-arms the loader for the next line. A per-channel mapper turns each latched bit into a 3-bit drive-level code. It uses the frame polarity for this, and the active-low display-off input overrides it.

Top module: `seg_col_loader`

## Requirements
- R1: After reset the output latch is all zero, the fill position is the first word and both enable outputs are high (inactive). With frame low and display on, every channel therefore shows code 3 (V3).
- R2: In 4-bit mode with `dir_i`=1, word k (counted from 0) writes `data_i[j]` to channel index 4k+3-j, for j=0..3. Channel index 0 is output 1. `data_i[7:4]` is ignored.
- R3: In 4-bit mode with `dir_i`=0, word k writes `data_i[j]` to channel index NUM_CH-4(k+1)+j. The first word therefore lands on the four highest channels, with `data_i[0]` on the lowest of them.
- R4: In 8-bit mode (`wide_i`=1), word k writes `data_i[j]` to index 8k+7-j when `dir_i`=1, and to index NUM_CH-8(k+1)+j when `dir_i`=0.
- R5: A shift strobe is ignored while the active enable input is high. The buffer and the fill position stay unchanged.
- R6: With `dir_i`=1, `en_a_i` is the enable input and `en_b_o` is the enable output (`en_b_oe_o`=1, `en_a_oe_o`=0). With `dir_i`=0 the roles swap. The pin that is not the output drives 1, and the pin that is not the input has no effect.
- R7: A line takes NUM_CH/4 words in 4-bit mode and NUM_CH/8 words in 8-bit mode. The enable output goes low from the cycle after the last word is accepted. Further shift strobes are then ignored until the next line pulse.
- R8: On a falling edge of `lp_i`, detected at a clock edge, the buffer is copied into the latch, visible after that edge. The same edge resets the fill position and returns the enable output high. A shift strobe in that same cycle is ignored.
- R9: With display on (`disp_on_ni`=1), the code per channel is 3 for frame 0 and bit 0, 5 for frame 0 and bit 1, 2 for frame 1 and bit 0, and 0 for frame 1 and bit 1 (codes V0..V5 = 0..5).
- R10: While `disp_on_ni` is 0, every channel shows code 5 regardless of frame or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_i | input | 1 | Shift strobe, one data word per asserted cycle |
| data_i | input | 8 | Parallel pixel word; bits 3:0 only in 4-bit mode |
| wide_i | input | 1 | 1 = 8-bit words, 0 = 4-bit words |
| dir_i | input | 1 | Fill direction and enable pin role select |
| en_a_i | input | 1 | Enable pin A input side, active low |
| en_b_i | input | 1 | Enable pin B input side, active low |
| en_a_o | output | 1 | Enable pin A output side, active low |
| en_b_o | output | 1 | Enable pin B output side, active low |
| en_a_oe_o | output | 1 | Pin A acts as output |
| en_b_oe_o | output | 1 | Pin B acts as output |
| lp_i | input | 1 | Line pulse; falling edge latches the line |
| fr_i | input | 1 | Frame polarity |
| disp_on_ni | input | 1 | Display off when low |
| level_o | output | 3*NUM_CH | Drive-level code per channel, channel i at bits 3i+2:3i |

## Verification
The bench builds the block with NUM_CH=16. A 4-bit line is then four words and an 8-bit line two words. This makes it practical to sweep every combination of width and direction against several data patterns, and to compare every channel under all four frame and display-off combinations. At this small size, the word-count boundary, the strobes after a full line, a strobe that lands on the line-pulse edge and the enable role swap can all be reached in a few cycles each.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NARROW_W = 4;
  localparam int WIDE_W   = 8;

  typedef enum logic [2:0] {
    LVL_V0 = 3'd0,
    LVL_V1 = 3'd1,
    LVL_V2 = 3'd2,
    LVL_V3 = 3'd3,
    LVL_V4 = 3'd4,
    LVL_V5 = 3'd5
  } lvl_e;

  function automatic lvl_e col_level(input logic bit_i, input logic fr, input logic disp_on_n);
    if (!disp_on_n) return LVL_V5;
    case ({fr, bit_i})
      2'b00:   return LVL_V3;
      2'b01:   return LVL_V5;
      2'b10:   return LVL_V2;
      default: return LVL_V0;
    endcase
  endfunction
endpackage

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl #(
  parameter int NUM_CH = 160,
  localparam int WORDS_N = NUM_CH / seg_pkg::NARROW_W,
  localparam int WORDS_W = NUM_CH / seg_pkg::WIDE_W,
  localparam int CNT_W = $clog2(WORDS_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             wide_i,
  input  logic             en_in_ni,
  input  logic             lp_fall_i,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] word_cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic             full_q;

  assign last_idx = wide_i ? CNT_W'(WORDS_W - 1) : CNT_W'(WORDS_N - 1);
  assign wr_en_o  = shift_i & ~en_in_ni & ~full_q & ~lp_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (lp_fall_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (wr_en_o) begin
      if (cnt_q == last_idx) begin
        cnt_q  <= '0;
        full_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_cnt_o = cnt_q;
  assign full_o     = full_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WORDS_N)); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !lp_fall_i) |=> (full_q && $stable(cnt_q))); // R7
  AST_EN_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_in_ni && !lp_fall_i) |=> ($stable(cnt_q) && $stable(full_q))); // R5
  AST_LP_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_fall_i |=> (!full_q && cnt_q == '0)); // R8
endmodule

// File: rtl/seg_line_buf.sv
module seg_line_buf #(
  parameter int NUM_CH = 160,
  localparam int WORDS_N = NUM_CH / seg_pkg::NARROW_W,
  localparam int CNT_W = $clog2(WORDS_N + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [CNT_W-1:0]          word_cnt_i,
  input  logic                      wide_i,
  input  logic                      dir_i,
  input  logic [seg_pkg::WIDE_W-1:0] data_i,
  input  logic                      lp_fall_i,
  output logic [NUM_CH-1:0]         latch_o
);
  localparam int NW = seg_pkg::NARROW_W;
  localparam int WW = seg_pkg::WIDE_W;

  logic [NUM_CH-1:0] buf_q, latch_q, hit, din;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // word index and data bit that reach channel i, per mode
    localparam logic [CNT_W-1:0] K_NF = CNT_W'(i / NW);
    localparam logic [2:0]       J_NF = 3'(NW - 1 - i % NW);
    localparam logic [CNT_W-1:0] K_NR = CNT_W'((NUM_CH - 1 - i) / NW);
    localparam logic [2:0]       J_NR = 3'(NW - 1 - (NUM_CH - 1 - i) % NW);
    localparam logic [CNT_W-1:0] K_WF = CNT_W'(i / WW);
    localparam logic [2:0]       J_WF = 3'(WW - 1 - i % WW);
    localparam logic [CNT_W-1:0] K_WR = CNT_W'((NUM_CH - 1 - i) / WW);
    localparam logic [2:0]       J_WR = 3'(WW - 1 - (NUM_CH - 1 - i) % WW);

    logic [CNT_W-1:0] sel_k;
    logic [2:0]       sel_j;

    always_comb begin
      case ({wide_i, dir_i})
        2'b01:   begin sel_k = K_NF; sel_j = J_NF; end
        2'b00:   begin sel_k = K_NR; sel_j = J_NR; end
        2'b11:   begin sel_k = K_WF; sel_j = J_WF; end
        default: begin sel_k = K_WR; sel_j = J_WR; end
      endcase
    end

    assign hit[i] = wr_en_i && (word_cnt_i == sel_k);
    assign din[i] = data_i[sel_j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      latch_q <= '0;
    end else begin
      buf_q <= (buf_q & ~hit) | (din & hit);
      if (lp_fall_i) latch_q <= buf_q;
    end
  end

  assign latch_o = latch_q;

  AST_WORD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ($countones(hit) == (wide_i ? WW : NW))); // R4
  AST_NO_HIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(buf_q)); // R5
  AST_LATCH_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_fall_i |=> (latch_q == $past(buf_q))); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_fall_i |=> $stable(latch_q)); // R8
endmodule

// File: rtl/seg_level_map.sv
module seg_level_map #(
  parameter int NUM_CH = 160
) (
  input  logic [NUM_CH-1:0]   latch_i,
  input  logic                fr_i,
  input  logic                disp_on_ni,
  output logic [3*NUM_CH-1:0] level_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_map
    assign level_o[3*i +: 3] = seg_pkg::col_level(latch_i[i], fr_i, disp_on_ni);
  end
endmodule

// File: rtl/seg_col_loader.sv
module seg_col_loader #(
  parameter int NUM_CH = 160,
  localparam int WORDS_N = NUM_CH / seg_pkg::NARROW_W,
  localparam int CNT_W = $clog2(WORDS_N + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       shift_i,
  input  logic [seg_pkg::WIDE_W-1:0] data_i,
  input  logic                       wide_i,
  input  logic                       dir_i,
  input  logic                       en_a_i,
  input  logic                       en_b_i,
  output logic                       en_a_o,
  output logic                       en_b_o,
  output logic                       en_a_oe_o,
  output logic                       en_b_oe_o,
  input  logic                       lp_i,
  input  logic                       fr_i,
  input  logic                       disp_on_ni,
  output logic [3*NUM_CH-1:0]        level_o
);
  logic             lp_q, lp_fall, en_in_n, wr_en, full;
  logic [CNT_W-1:0] word_cnt;
  logic [NUM_CH-1:0] latch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_q <= 1'b0;
    else         lp_q <= lp_i;
  end
  assign lp_fall = lp_q & ~lp_i;

  // dir_i=1: A in, B out; dir_i=0: B in, A out
  assign en_in_n   = dir_i ? en_a_i : en_b_i;
  assign en_a_o    = dir_i ? 1'b1 : ~full;
  assign en_b_o    = dir_i ? ~full : 1'b1;
  assign en_a_oe_o = ~dir_i;
  assign en_b_oe_o = dir_i;

  seg_fill_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk_i, .rst_ni, .shift_i, .wide_i,
    .en_in_ni  (en_in_n),
    .lp_fall_i (lp_fall),
    .wr_en_o   (wr_en),
    .word_cnt_o(word_cnt),
    .full_o    (full)
  );

  seg_line_buf #(.NUM_CH(NUM_CH)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .word_cnt_i(word_cnt),
    .wide_i, .dir_i, .data_i,
    .lp_fall_i (lp_fall),
    .latch_o   (latch)
  );

  seg_level_map #(.NUM_CH(NUM_CH)) u_map (
    .latch_i   (latch),
    .fr_i, .disp_on_ni,
    .level_o
  );

  AST_DSPOFF_V5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_ni |-> (level_o == {NUM_CH{3'd5}})); // R10
  AST_OE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({en_a_oe_o, en_b_oe_o}) == 1); // R6
  AST_ENOUT_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_fall |=> (en_a_o && en_b_o)); // R8
endmodule

// File: tb/tb_seg_col_loader.sv
module tb_seg_col_loader;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shift = 1'b0, wide = 1'b0, dir = 1'b1;
  logic [7:0] data = '0;
  logic en_a_i = 1'b1, en_b_i = 1'b1, en_a_o, en_b_o, en_a_oe, en_b_oe;
  logic lp = 1'b0, fr = 1'b0, disp_on_n = 1'b1;
  logic [3*N-1:0] level;

  int n_run = 0, n_fail = 0, cnt = 0;
  logic [N-1:0] exp_buf = '0, exp_lat = '0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  seg_col_loader #(.NUM_CH(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .data_i(data),
    .wide_i(wide), .dir_i(dir), .en_a_i(en_a_i), .en_b_i(en_b_i),
    .en_a_o(en_a_o), .en_b_o(en_b_o), .en_a_oe_o(en_a_oe), .en_b_oe_o(en_b_oe),
    .lp_i(lp), .fr_i(fr), .disp_on_ni(disp_on_n), .level_o(level)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int words_per_line();
    return wide ? N / 8 : N / 4;
  endfunction

  function automatic int ch_index(input int k, input int j);
    int w;
    w = wide ? 8 : 4;
    return dir ? (w * k + w - 1 - j) : (N - w * (k + 1) + j);
  endfunction

  function automatic logic [2:0] exp_lvl(input logic b, input logic f, input logic don);
    if (!don) return 3'd5;
    case ({f, b})
      2'b00:   return 3'd3;
      2'b01:   return 3'd5;
      2'b10:   return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic en_out();
    return dir ? en_b_o : en_a_o;
  endfunction

  task automatic set_en(input bit active);
    if (dir) begin en_a_i = ~active; en_b_i = 1'b1; end
    else     begin en_b_i = ~active; en_a_i = 1'b1; end
  endtask

  // drive one strobe; model acceptance per R5/R7
  task automatic shift_word(input logic [7:0] d, input bit en_ok);
    @(negedge clk);
    data = d; shift = 1'b1;
    @(negedge clk);
    shift = 1'b0;
    if (en_ok && cnt < words_per_line()) begin
      for (int j = 0; j < (wide ? 8 : 4); j++) exp_buf[ch_index(cnt, j)] = d[j];
      cnt++;
    end
  endtask

  task automatic pulse_lp();
    @(negedge clk); lp = 1'b1;
    @(negedge clk); lp = 1'b0;
    @(negedge clk);
    exp_lat = exp_buf; cnt = 0;
  endtask

  task automatic check_levels(input string req);
    for (int f = 0; f < 2; f++) begin
      for (int d = 0; d < 2; d++) begin
        fr = f[0]; disp_on_n = d[0];
        #1;
        for (int i = 0; i < N; i++) begin
          logic [2:0] e;
          e = exp_lvl(exp_lat[i], f[0], d[0]);
          check(level[3*i +: 3] == e, d[0] ? req : "R10",
                $sformatf("ch%0d fr%0d don%0d", i, f, d), level[3*i +: 3], e);
        end
      end
    end
    fr = 1'b0; disp_on_n = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int k, input int s);
    return 8'((k * 37 + s * 91 + 5) ^ (s * 13));
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(en_a_o && en_b_o, "R1", "enable outs after reset", {en_a_o, en_b_o}, 3);
    check_levels("R1");

    for (int w = 0; w < 2; w++) begin
      for (int dd = 0; dd < 2; dd++) begin
        wide = w[0]; dir = dd[0];
        @(negedge clk);
        // R6 pin roles
        check(en_b_oe == dir && en_a_oe == !dir, "R6", "oe roles", {en_a_oe, en_b_oe}, {!dir, dir});
        for (int s = 0; s < 3; s++) begin
          set_en(1'b1);
          for (int k = 0; k < words_per_line(); k++) begin
            check(en_out() == 1'b1, "R7", "enable out before full", en_out(), 1);
            shift_word(pat(k, s + 4 * w + 2 * dd), 1'b1);
          end
          check(en_out() == 1'b0, "R7", "enable out after full", en_out(), 0);
          // extra strobes after full are ignored
          shift_word(8'hA5, 1'b1);
          shift_word(8'h3C, 1'b1);
          pulse_lp();
          check(en_out() == 1'b1, "R8", "enable out after LP", en_out(), 1);
          check_levels(w ? "R4 R9" : (dd ? "R2 R9" : "R3 R9"));
        end
        // R5 enable inactive: strobes ignored
        set_en(1'b0);
        for (int k = 0; k < words_per_line(); k++) shift_word(~pat(k, 7), 1'b0);
        check(en_out() == 1'b1, "R5", "enable out stays high", en_out(), 1);
        pulse_lp();
        check_levels("R5");
        // R6 driving the output-role pin low does not enable
        if (dir) begin en_a_i = 1'b1; en_b_i = 1'b0; end
        else     begin en_b_i = 1'b1; en_a_i = 1'b0; end
        for (int k = 0; k < words_per_line(); k++) shift_word(pat(k, 9), 1'b0);
        check(en_out() == 1'b1, "R6", "output pin not an input", en_out(), 1);
        pulse_lp();
        check_levels("R6");
        // R8 strobe coinciding with LP fall is ignored
        set_en(1'b1);
        @(negedge clk); lp = 1'b1;
        @(negedge clk); lp = 1'b0; data = 8'hFF; shift = 1'b1;
        @(negedge clk); shift = 1'b0;
        exp_lat = exp_buf; cnt = 0;
        pulse_lp();
        check_levels("R8");
        shift_word(8'h5A, 1'b1);
        pulse_lp();
        check_levels("R8");
        for (int k = 1; k < words_per_line(); k++) shift_word(pat(k, 11), 1'b1);
        check(en_out() == 1'b1, "R8", "fill position reset by LP", en_out(), 1);
        pulse_lp();
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule